// File: doc/BRIEF.md
# I2C Target Protocol Engine

This block is a synchronous I2C target that works from SCL and SDA levels that are already synchronized to the system clock. It drives one output: an active-high enable for an external open-drain pull-down on SDA. It finds bus START and STOP conditions and takes in the 8-bit address byte. When the 7-bit address matches a parameter, it runs the transfer against a small on-chip register file.

A write transfer acknowledges every byte. The first data byte after a write-direction START sets the register pointer. Each byte after that is stored at the pointer, and the pointer then steps forward. A read transfer acknowledges the address and then sends the register at the pointer, most significant bit first. It keeps sending successive registers for as long as the controller acknowledges. A not-acknowledge from the controller releases the bus and takes the engine back to idle.

Internally there are four states: idle, address collection, receive and send. One response shift register with a down-counter covers both the one-slot acknowledge and the nine-slot transmit frame. The ninth slot of a transmit frame stays released so the controller can answer.

Top module: `i2c_target_engine`

## Requirements
- R1: An SDA fall while SCL is high (START) is honoured in every state. It enters address collection with an empty shift register, drops any transfer in progress and releases SDA, so a partly shifted byte is never stored.
- R2: An SDA rise while SCL is high (STOP) returns the engine to idle with SDA released and closes the backend transfer. Bytes clocked after a STOP without a new START get no acknowledge.
- R3: Bits are sampled on each SCL rise, MSB first. In the first byte after START, bits 7..1 are the address and bit 0 is the direction, with 1 meaning read.
- R4: On an address mismatch the engine never pulls SDA and ignores all SCL activity until the next START, in either direction.
- R5: After a matching address byte, SDA is pulled low from the SCL fall that ends bit 8 until the next SCL fall (the ninth slot), and only then.
- R6: Every data byte received in a write transfer is acknowledged in its ninth slot.
- R7: The first data byte of a write transfer loads the pointer from its low 4 bits. Each later byte is stored at the pointer, and the pointer then increments.
- R8: In a read, SDA changes only while SCL is low. Each frame holds 8 data bits MSB first, followed by a released ninth slot.
- R9: If the controller drives the ninth slot low, the next register is sent. If it leaves the slot high, SDA stays released and the engine goes idle, even when the next register holds zero.
- R10: After reset the engine is idle with SDA released, all 16 registers read as zero, and the pointer is 0.
- R11: The pointer wraps from 15 to 0 on both reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Synchronized SCL level |
| sda | input | 1 | Synchronized SDA bus level (wired-AND result) |
| sda_pull | output | 1 | Active-high SDA pull-down enable |

## Verification
The bench targets these corner cases:
- A START in the middle of a byte. A design that stored the partial byte would corrupt the addressed register.
- A not-acknowledge where the next register holds zero. A design that ignored the controller's answer would pull SDA low there.
- A STOP followed by bytes with no new START, and a foreign address in both directions. A design that missed either case would acknowledge or drive data it does not own.
- Pointer wrap across register 15, a pointer byte arriving as the first write, and SDA stability through every SCL-high phase of a read. These catch an off-by-one in the pointer logic or a release timed to the wrong clock edge.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int FRAME_W   = BYTE_W + 1;
    localparam int ACK_SLOTS = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RECV,
        ST_SEND
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef struct packed {
        logic              open_xfer;
        logic              is_read;
        logic              close_xfer;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_byte;
        logic              rd_adv;
    } reg_req_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                      input logic [ADDR_W-1:0] own);
        return frame[BYTE_W-1:1] == own;
    endfunction

endpackage

// File: rtl/i2c_tgt_cond.sv
`timescale 1ns/1ps
module i2c_tgt_cond import i2c_tgt_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev,
    output logic    bit_val,
    output logic    bit_ok
);
    logic scl_q;
    logic sda_q;

    always_comb begin
        ev.start = scl && scl_q && sda_q && !sda;
        ev.stop  = scl && scl_q && !sda_q && sda;
        ev.rise  = scl && !scl_q;
        ev.fall  = !scl && scl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            bit_val <= 1'b1;
            bit_ok  <= 1'b0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            if (ev.rise) begin
                bit_val <= sda;
                bit_ok  <= 1'b1;
            end else if (ev.start || ev.fall) begin
                bit_ok  <= 1'b0;
            end
        end
    end

    // R3: a bit is captured from SDA at the SCL rise
    assert_rise_capture_R3: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> (bit_ok && bit_val == $past(sda)));

endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
module i2c_tgt_fsm import i2c_tgt_pkg::*; #(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              bit_val,
    input  logic              bit_ok,
    input  logic [BYTE_W-1:0] rd_byte,
    output reg_req_t          req,
    output logic              sda_pull
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int IDX_W = $clog2(BYTE_W);

    eng_state_t        state;
    logic [IDX_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic [FRAME_W-1:0] resp;
    logic [CNT_W-1:0]  resp_cnt;

    logic [BYTE_W-1:0] next_frame;
    logic              collecting;
    logic              byte_done;
    logic              frame_end;

    assign next_frame = {shreg[BYTE_W-2:0], bit_val};
    assign collecting = ev.fall && bit_ok && (resp_cnt == '0) &&
                        (state == ST_ADDR || state == ST_RECV);
    assign byte_done  = collecting && (bit_idx == IDX_W'(BYTE_W - 1));
    assign frame_end  = ev.fall && (resp_cnt == CNT_W'(1));
    assign sda_pull   = (resp_cnt != '0) && !resp[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_idx  <= '0;
            shreg    <= '0;
            resp     <= '0;
            resp_cnt <= '0;
            req      <= '0;
        end else begin
            req <= '0;
            if (ev.start) begin
                state    <= ST_ADDR;
                bit_idx  <= '0;
                shreg    <= '0;
                resp     <= '0;
                resp_cnt <= '0;
            end else if (ev.stop) begin
                state          <= ST_IDLE;
                bit_idx        <= '0;
                resp           <= '0;
                resp_cnt       <= '0;
                req.close_xfer <= 1'b1;
            end else if (ev.fall && resp_cnt != '0) begin
                // shift the response frame, refilling with released slots
                resp     <= {resp[FRAME_W-2:0], 1'b1};
                resp_cnt <= resp_cnt - 1'b1;
                if (frame_end && state == ST_SEND) begin
                    if (bit_ok && !bit_val) begin
                        resp       <= {rd_byte, 1'b1};
                        resp_cnt   <= CNT_W'(FRAME_W);
                        req.rd_adv <= 1'b1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
            end else if (collecting) begin
                shreg   <= next_frame;
                bit_idx <= bit_idx + 1'b1;
                if (byte_done) begin
                    if (state == ST_ADDR) begin
                        if (addr_hit(next_frame, OWN_ADDR)) begin
                            req.open_xfer <= 1'b1;
                            req.is_read   <= next_frame[0];
                            resp          <= '0;
                            resp_cnt      <= CNT_W'(ACK_SLOTS);
                            state         <= next_frame[0] ? ST_SEND : ST_RECV;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        req.wr_en   <= 1'b1;
                        req.wr_byte <= next_frame;
                        resp        <= '0;
                        resp_cnt    <= CNT_W'(ACK_SLOTS);
                    end
                end
            end
        end
    end

    assert_start_enters_addr_R1: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && !sda_pull));

    assert_stop_goes_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_pull && req.close_xfer));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull);

    assert_mismatch_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_ADDR && !addr_hit(next_frame, OWN_ADDR))
            |=> (state == ST_IDLE && !sda_pull));

    assert_data_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_RECV) |=> (sda_pull && req.wr_en));

    assert_frame_bound_R8: assert property (@(posedge clk) disable iff (rst)
        resp_cnt <= CNT_W'(FRAME_W));

endmodule

// File: rtl/i2c_tgt_regs.sv
`timescale 1ns/1ps
module i2c_tgt_regs import i2c_tgt_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  ptr_inc;
    logic              arm;

    assign ptr_inc = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    assign rd_byte = mem[ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            arm <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (req.open_xfer) begin
                arm <= !req.is_read;
            end
            if (req.close_xfer) begin
                arm <= 1'b0;
            end
            if (req.wr_en) begin
                if (arm) begin
                    ptr <= req.wr_byte[PTR_W-1:0];
                    arm <= 1'b0;
                end else begin
                    mem[ptr] <= req.wr_byte;
                    ptr      <= ptr_inc;
                end
            end
            if (req.rd_adv) begin
                ptr <= ptr_inc;
            end
        end
    end

    assert_pointer_load_R7: assert property (@(posedge clk) disable iff (rst)
        (req.wr_en && arm) |=> (ptr == $past(req.wr_byte[PTR_W-1:0]) && !arm));

    assert_pointer_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        ((req.rd_adv || (req.wr_en && !arm)) && ptr == PTR_W'(DEPTH - 1)) |=> (ptr == '0));

endmodule

// File: rtl/i2c_target_engine.sv
`timescale 1ns/1ps
module i2c_target_engine import i2c_tgt_pkg::*; #(
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h50,
    parameter int                REG_DEPTH   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic sda_pull
);
    bus_ev_t           ev;
    logic              bit_val;
    logic              bit_ok;
    reg_req_t          req;
    logic [BYTE_W-1:0] rd_byte;

    i2c_tgt_cond u_cond (
        .clk     (clk),
        .rst     (rst),
        .scl     (scl),
        .sda     (sda),
        .ev      (ev),
        .bit_val (bit_val),
        .bit_ok  (bit_ok)
    );

    i2c_tgt_fsm #(.OWN_ADDR(TARGET_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .bit_val  (bit_val),
        .bit_ok   (bit_ok),
        .rd_byte  (rd_byte),
        .req      (req),
        .sda_pull (sda_pull)
    );

    i2c_tgt_regs #(.DEPTH(REG_DEPTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rd_byte (rd_byte)
    );

    // R8: the pull-down only moves while SCL is low
    assert_sda_moves_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl);

endmodule

// File: tb/i2c_target_engine_tb.sv
`timescale 1ns/1ps
module i2c_target_engine_tb;

    localparam int         HALF = 4;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         NV   = 6;
    // {pointer[3:0], data[7:0]}
    localparam logic [11:0] VEC [NV] = '{12'h0A5, 12'hF5A, 12'h700,
                                         12'h8FF, 12'h381, 12'hC7E};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic ctrl_low = 1'b0;
    logic sda_pull;
    logic sda;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [16];

    assign sda = ~(ctrl_low | sda_pull);

    always #2.5 clk = ~clk;

    i2c_target_engine u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl      (scl),
        .sda      (sda),
        .sda_pull (sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        ctrl_low = !b;
        tick(HALF);
        scl = 1'b1;
        tick(HALF / 2);
        seen = sda;
        tick(HALF / 2);
        scl = 1'b0;
        tick(HALF);
    endtask

    task automatic bus_start();
        ctrl_low = 1'b0;
        tick(HALF);
        scl = 1'b1;
        tick(HALF);
        ctrl_low = 1'b1;
        tick(HALF);
        scl = 1'b0;
        tick(HALF);
    endtask

    task automatic bus_stop();
        ctrl_low = 1'b1;
        tick(HALF);
        scl = 1'b1;
        tick(HALF);
        ctrl_low = 1'b0;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic stray);
        logic s;
        stray = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(b[i], s);
            if (b[i] && !s) stray = 1'b1;
        end
        bus_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d, output logic unstable);
        logic s1, s2, s;
        unstable = 1'b0;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            ctrl_low = 1'b0;
            tick(HALF);
            scl = 1'b1;
            tick(1);
            s1 = sda;
            tick(HALF - 2);
            s2 = sda;
            tick(1);
            scl = 1'b0;
            tick(HALF);
            d = {d[6:0], s1};
            if (s1 != s2) unstable = 1'b1;
        end
        bus_bit(give_ack ? 1'b0 : 1'b1, s);
    endtask

    task automatic write_one(input logic [3:0] p, input logic [7:0] v);
        logic a0, a1, a2, s0, s1, s2;
        bus_start();
        send_byte({DEV, 1'b0}, a0, s0);
        send_byte({4'h0, p}, a1, s1);
        send_byte(v, a2, s2);
        bus_stop();
        check(a0, "R5 address ack", 32'(a0), 32'd1);
        check(a1 && a2, "R6 data ack", 32'({a1, a2}), 32'h3);
        check(!(s0 | s1 | s2), "R5 no pull outside ack slot", 32'({s0, s1, s2}), 32'h0);
        model[p] = v;
    endtask

    task automatic read_at(input logic [3:0] p, output logic [7:0] d, output logic unst);
        logic a, s;
        bus_start();
        send_byte({DEV, 1'b0}, a, s);
        send_byte({4'h0, p}, a, s);
        bus_start();
        send_byte({DEV, 1'b1}, a, s);
        check(a, "R3 read address ack", 32'(a), 32'd1);
        recv_byte(1'b0, d, unst);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d, d1, d2;
        logic u, a, s;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;

        tick(5);
        rst = 1'b0;
        tick(3);

        // R10: reset state
        check(!sda_pull && sda, "R10 released after reset", 32'({sda_pull, sda}), 32'h1);
        bus_start();
        send_byte({DEV, 1'b1}, a, s);
        check(a, "R3 read direction ack", 32'(a), 32'd1);
        recv_byte(1'b0, d, u);
        bus_stop();
        check(d == 8'h00, "R10 register 0 zero after reset", 32'(d), 32'h0);

        // vector walk: R7 pointer load and store, R8 stable read
        for (int k = 0; k < NV; k++) begin
            write_one(VEC[k][11:8], VEC[k][7:0]);
            read_at(VEC[k][11:8], d, u);
            check(d == model[VEC[k][11:8]], "R7 readback", 32'(d), 32'(model[VEC[k][11:8]]));
            check(!u, "R8 SDA stable while SCL high", 32'(u), 32'h0);
        end

        // burst write across the wrap: R11, R6
        bus_start();
        send_byte({DEV, 1'b0}, a, s);
        send_byte(8'h0E, a, s);
        send_byte(8'hA1, a, s);
        check(a, "R6 burst byte 1 ack", 32'(a), 32'd1);
        send_byte(8'hB2, a, s);
        check(a, "R6 burst byte 2 ack", 32'(a), 32'd1);
        send_byte(8'h00, a, s);
        check(a, "R6 burst byte 3 ack", 32'(a), 32'd1);
        bus_stop();
        model[14] = 8'hA1; model[15] = 8'hB2; model[0] = 8'h00;

        // burst read with controller ack: R9, R11
        bus_start();
        send_byte({DEV, 1'b0}, a, s);
        send_byte(8'h0E, a, s);
        bus_start();
        send_byte({DEV, 1'b1}, a, s);
        recv_byte(1'b1, d, u);
        recv_byte(1'b1, d1, u);
        recv_byte(1'b0, d2, u);
        bus_stop();
        check(d == 8'hA1 && d1 == 8'hB2, "R9 continued read", 32'({d, d1}), 32'hA1B2);
        check(d2 == 8'h00, "R11 read wraps to register 0", 32'(d2), 32'h0);

        // NACK with a zero next register: R9 release
        bus_start();
        send_byte({DEV, 1'b0}, a, s);
        send_byte(8'h0F, a, s);
        bus_start();
        send_byte({DEV, 1'b1}, a, s);
        recv_byte(1'b0, d, u);
        check(d == 8'hB2, "R9 last byte value", 32'(d), 32'hB2);
        check(!sda_pull && sda, "R9 released after not-acknowledge", 32'({sda_pull, sda}), 32'h1);
        bus_stop();

        // foreign address, write then read: R4
        bus_start();
        send_byte({7'h51, 1'b0}, a, s);
        check(!a, "R4 no ack for foreign write address", 32'(a), 32'd0);
        send_byte(8'hFF, a, s);
        check(!a && !s, "R4 ignored after mismatch", 32'({a, s}), 32'h0);
        bus_start();
        send_byte({7'h28, 1'b1}, a, s);
        recv_byte(1'b0, d, u);
        check(!a && d == 8'hFF, "R4 no data for foreign read", 32'({a, d}), 32'hFF);
        bus_stop();

        // START in the middle of a data byte: R1
        write_one(4'd5, 8'h3C);
        bus_start();
        send_byte({DEV, 1'b0}, a, s);
        send_byte(8'h05, a, s);
        for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
        bus_start();
        check(!sda_pull, "R1 released after START", 32'(sda_pull), 32'h0);
        send_byte({DEV, 1'b1}, a, s);
        check(a, "R1 address accepted after START", 32'(a), 32'd1);
        recv_byte(1'b0, d, u);
        bus_stop();
        check(d == 8'h3C, "R1 partial byte not stored", 32'(d), 32'h3C);

        // STOP closes the transfer: R2
        bus_start();
        send_byte({DEV, 1'b0}, a, s);
        send_byte(8'h07, a, s);
        bus_stop();
        check(!sda_pull, "R2 released after STOP", 32'(sda_pull), 32'h0);
        scl = 1'b0;
        tick(HALF);
        send_byte({DEV, 1'b0}, a, s);
        check(!a, "R2 no ack without new START", 32'(a), 32'd0);
        send_byte(8'h99, a, s);
        check(!a, "R2 data ignored after STOP", 32'(a), 32'd0);
        read_at(4'd7, d, u);
        check(d == model[7], "R2 register untouched", 32'(d), 32'(model[7]));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule